// File: doc/BRIEF.md
# Packed SIMD Signed Averaging Add/Subtract Unit

This block takes two 64-bit operand words and treats them as packed signed lanes of 8, 16, 32 or 64 bits. For every lane it forms the signed sum or difference of the two lane values at one bit more than the lane width. It then halves that value with an arithmetic right shift and adds a one-bit rounding increment. One of four fixed-point rounding modes picks the increment. The halved result is exact at every width. For each lane the carry that falls off the top of the lane-wide adder is recovered from the signed-overflow condition of that lane, so no wider adder is needed.

The second operand can come from three places. It can be the second vector word. It can be the low element-width bits of a scalar word, broadcast to every lane. It can be a sign-extended 5-bit immediate, broadcast to every lane, and in that case the operation is always an add. A per-lane mask can replace the result of any lane with that lane of an old destination word. Results leave through a one-entry registered stage with a valid/ready handshake.

Top module: `simd_avg_unit`

## Requirements
- R1: After reset, `out_valid` is 0, and `in_ready` is 1 within three clock cycles of reset release.
- R2: For each active lane of width W, the lane result is floor((a ± b) / 2) + inc, taken modulo 2^W. Here a and b are the signed lane values and the sum or difference is exact at W+1 bits. `op_sub` = 1 selects the difference. Lane i occupies bits [i*W +: W].
- R3: `elem_sz` selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R4: Let s be the exact wide sum or difference, with s[0] the bit discarded by the halving and s[1] the kept LSB. The increment depends on `rnd_mode`: 0 adds s[0]; 1 adds s[0] AND s[1]; 2 adds nothing; 3 adds s[0] AND NOT s[1].
- R5: 64-bit lanes give the exact result even when the 64-bit add or subtract overflows. This includes max+max, min+min and min−max.
- R6: `opnd_sel` picks the second operand: 0 = `src_b`; 1 = `scalar[W-1:0]` broadcast to every lane; 2 = `imm5` sign-extended to W bits and broadcast to every lane; 3 behaves as 0.
- R7: When `opnd_sel` = 2, the lane operation is an add whatever the value of `op_sub`.
- R8: When `mask_en` = 1 and `mask[i]` = 0, lane i of the result equals lane i of `old_dst`. When `mask_en` = 0, `mask` has no effect and every lane is computed.
- R9: `in_ready` = 1 exactly when the output stage is empty or is being drained in the same cycle. An input taken on a clock edge (`in_valid` and `in_ready` both 1) shows up on `out_data` with `out_valid` = 1 straight after that edge.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_data` hold their values.
- R11: After an output handshake with no input taken on the same edge, `out_valid` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| op_sub | input | 1 | 1 = average of difference, 0 = average of sum |
| elem_sz | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| rnd_mode | input | 2 | Rounding mode (0 nearest-up, 1 nearest-even, 2 down, 3 odd) |
| opnd_sel | input | 2 | Second operand source (0 vector, 1 scalar, 2 immediate) |
| src_a | input | 64 | First operand word |
| src_b | input | 64 | Second operand word |
| scalar | input | 64 | Scalar for broadcast |
| imm5 | input | 5 | Signed immediate for broadcast |
| mask_en | input | 1 | Enable per-lane masking |
| mask | input | 8 | Per-lane active bits, bit i for lane i |
| old_dst | input | 64 | Value passed through on masked-off lanes |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Packed lane results |

## Verification
Every accepted operation must show its result one clock edge after the edge that takes it, and it stays there until the edge on which `out_ready` is seen high. The bench drives inputs on the falling edge and works out from the port values which handshakes the next rising edge will complete. It keeps a queue of expected results computed with exact wide arithmetic and compares `out_valid` and `out_data` against the head of that queue at every falling edge. Stalls, drains and back-to-back transfers are each checked in the cycle right after the edge that caused them.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

  localparam int DATA_W   = 64;
  localparam int NUM_SZ   = 4;               // 8,16,32,64-bit lanes
  localparam int MIN_EW   = 8;
  localparam int MAX_LN   = DATA_W / MIN_EW; // lanes at the narrowest width
  localparam int SZ_W     = $clog2(NUM_SZ);
  localparam int IMM_W    = 5;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ODD       = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    OPS_VEC    = 2'd0,
    OPS_SCALAR = 2'd1,
    OPS_IMM    = 2'd2,
    OPS_RSVD   = 2'd3
  } opnd_sel_e;

  // Increment after a one-bit halving: kept_lsb is bit 1 of the wide value,
  // lost is bit 0 that the shift drops.
  function automatic logic round_inc(rnd_mode_e mode, logic kept_lsb, logic lost);
    logic inc;
    unique case (mode)
      RND_NEAR_UP:   inc = lost;
      RND_NEAR_EVEN: inc = lost & kept_lsb;
      RND_ODD:       inc = lost & ~kept_lsb;
      default:       inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/simd_avg_opnd.sv
module simd_avg_opnd
  import simd_avg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]                 src_b,
  input  logic [DW-1:0]                 scalar,
  input  logic [IMM_W-1:0]              imm5,
  input  opnd_sel_e                     sel,
  input  logic                          op_sub,
  output logic [NUM_SZ-1:0][DW-1:0]     b_by_sz,
  output logic                          eff_sub
);

  // Immediate form is add-only.
  assign eff_sub = op_sub & (sel != OPS_IMM);

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    localparam int EW = MIN_EW << k;
    localparam int NL = DW / EW;
    logic [EW-1:0] bc_val;

    always_comb begin
      if (sel == OPS_IMM) bc_val = {{(EW-IMM_W){imm5[IMM_W-1]}}, imm5};
      else                bc_val = scalar[EW-1:0];
    end

    for (genvar i = 0; i < NL; i++) begin : g_ln
      assign b_by_sz[k][i*EW +: EW] =
        ((sel == OPS_SCALAR) || (sel == OPS_IMM)) ? bc_val : src_b[i*EW +: EW];
    end
  end

endmodule

// File: rtl/simd_avg_lane.sv
module simd_avg_lane
  import simd_avg_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          sub,
  input  rnd_mode_e     rmode,
  output logic [EW-1:0] y
);

  logic [EW-1:0] raw;
  logic [EW-1:0] half;
  logic          ovf;
  logic          inc;

  always_comb begin
    raw = sub ? (a - b) : (a + b);
    // Signed overflow means the true sign (bit EW of the wide value) is the
    // inverse of raw's top bit.
    if (sub) ovf = (raw[EW-1] ^ a[EW-1]) & (a[EW-1] ^ b[EW-1]);
    else     ovf = (raw[EW-1] ^ a[EW-1]) & (raw[EW-1] ^ b[EW-1]);
    half = {raw[EW-1] ^ ovf, raw[EW-1:1]};
    inc  = round_inc(rmode, raw[1], raw[0]);
    y    = half + EW'(inc);
  end

endmodule

// File: rtl/simd_avg_lanes.sv
module simd_avg_lanes
  import simd_avg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]             a,
  input  logic [NUM_SZ-1:0][DW-1:0] b_by_sz,
  input  logic                      sub,
  input  rnd_mode_e                 rmode,
  input  logic [SZ_W-1:0]           esz,
  input  logic                      mask_en,
  input  logic [DW/MIN_EW-1:0]      mask,
  input  logic [DW-1:0]             old_dst,
  output logic [DW-1:0]             y
);

  logic [NUM_SZ-1:0][DW-1:0] y_by_sz;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
    localparam int EW = MIN_EW << k;
    localparam int NL = DW / EW;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [EW-1:0] lane_y;
      logic          act;
      simd_avg_lane #(.EW(EW)) u_lane (
        .a     (a[i*EW +: EW]),
        .b     (b_by_sz[k][i*EW +: EW]),
        .sub   (sub),
        .rmode (rmode),
        .y     (lane_y)
      );
      assign act = ~mask_en | mask[i];
      assign y_by_sz[k][i*EW +: EW] = act ? lane_y : old_dst[i*EW +: EW];
    end
  end

  assign y = y_by_sz[esz];

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
  import simd_avg_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  op_sub,
  input  logic [SZ_W-1:0]       elem_sz,
  input  logic [1:0]            rnd_mode,
  input  logic [1:0]            opnd_sel,
  input  logic [DW-1:0]         src_a,
  input  logic [DW-1:0]         src_b,
  input  logic [DW-1:0]         scalar,
  input  logic [IMM_W-1:0]      imm5,
  input  logic                  mask_en,
  input  logic [DW/MIN_EW-1:0]  mask,
  input  logic [DW-1:0]         old_dst,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data
);

  logic [1:0]                rst_pipe;
  logic                      rst_ok;
  logic [NUM_SZ-1:0][DW-1:0] b_by_sz;
  logic                      eff_sub;
  logic [DW-1:0]             lane_res;
  logic                      load_en;
  logic                      vld_d, vld_q;
  logic [DW-1:0]             data_q;

  // Reset release synchronised to clk.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  simd_avg_opnd #(.DW(DW)) u_opnd (
    .src_b   (src_b),
    .scalar  (scalar),
    .imm5    (imm5),
    .sel     (opnd_sel_e'(opnd_sel)),
    .op_sub  (op_sub),
    .b_by_sz (b_by_sz),
    .eff_sub (eff_sub)
  );

  simd_avg_lanes #(.DW(DW)) u_lanes (
    .a       (src_a),
    .b_by_sz (b_by_sz),
    .sub     (eff_sub),
    .rmode   (rnd_mode_e'(rnd_mode)),
    .esz     (elem_sz),
    .mask_en (mask_en),
    .mask    (mask),
    .old_dst (old_dst),
    .y       (lane_res)
  );

  assign in_ready = rst_ok & (~vld_q | out_ready);
  assign load_en  = in_valid & in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= lane_res;
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

endmodule

// File: rtl/simd_avg_chk.sv
module simd_avg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        mask_en,
  input logic [7:0]  mask,
  input logic [63:0] old_dst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid); // R11

  AST_MASK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mask_en && !mask[0] |=> out_data[7:0] == $past(old_dst[7:0])); // R8

endmodule

bind simd_avg_unit simd_avg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mask_en   (mask_en),
  .mask      (mask),
  .old_dst   (old_dst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/simd_avg_unit_tb.sv
`timescale 1ns/1ps
module simd_avg_unit_tb;

  localparam real CLK_HALF = 4.0; // 125 MHz

  typedef struct {
    logic [63:0] a, b, sc, old;
    logic [4:0]  imm;
    logic        sub;
    logic [1:0]  esz, rm, ops;
    logic        men;
    logic [7:0]  mk;
  } stim_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, op_sub, mask_en, out_valid, out_ready;
  logic [1:0]  elem_sz, rnd_mode, opnd_sel;
  logic [63:0] src_a, src_b, scalar, old_dst, out_data;
  logic [4:0]  imm5;
  logic [7:0]  mask;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_HALF) clk = ~clk;

  simd_avg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .elem_sz(elem_sz), .rnd_mode(rnd_mode), .opnd_sel(opnd_sel),
    .src_a(src_a), .src_b(src_b), .scalar(scalar), .imm5(imm5),
    .mask_en(mask_en), .mask(mask), .old_dst(old_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Exact wide-arithmetic reference.
  function automatic logic [63:0] ref_avg(stim_t s);
    int w = 8 << s.esz;
    int nl = 64 / w;
    logic [63:0] res = '0;
    for (int i = 0; i < nl; i++) begin
      logic [63:0] xa, xb;
      logic signed [65:0] sa, sb, sum, kept, y;
      logic inc, do_sub;
      xa = s.a >> (i * w);
      if (s.ops == 2'd1)      xb = s.sc;
      else if (s.ops == 2'd2) xb = {{59{s.imm[4]}}, s.imm};
      else                    xb = s.b >> (i * w);
      for (int j = w; j < 64; j++) begin
        xa[j] = xa[w-1];
        xb[j] = xb[w-1];
      end
      sa = {{2{xa[63]}}, xa};
      sb = {{2{xb[63]}}, xb};
      do_sub = s.sub && (s.ops != 2'd2);
      sum  = do_sub ? sa - sb : sa + sb;
      kept = sum >>> 1;
      case (s.rm)
        2'd0: inc = sum[0];
        2'd1: inc = sum[0] & sum[1];
        2'd3: inc = sum[0] & ~sum[1];
        default: inc = 1'b0;
      endcase
      y = kept + {65'd0, inc};
      for (int j = 0; j < w; j++)
        res[i*w + j] = (s.men && !s.mk[i]) ? s.old[i*w + j] : y[j];
    end
    return res;
  endfunction

  // One cycle: drive at falling edge, predict handshakes, compare next falling edge.
  task automatic cycle(input stim_t s, input logic iv, input logic ordy, input string tag);
    logic fire_in, fire_out, stalled;
    logic [63:0] prev_data;
    in_valid = iv; out_ready = ordy;
    src_a = s.a; src_b = s.b; scalar = s.sc; old_dst = s.old; imm5 = s.imm;
    op_sub = s.sub; elem_sz = s.esz; rnd_mode = s.rm; opnd_sel = s.ops;
    mask_en = s.men; mask = s.mk;
    #1;
    chk({63'd0, in_ready}, {63'd0, (exp_q.size() == 0) || ordy}, "R9");
    fire_in  = iv && in_ready;
    fire_out = out_valid && ordy;
    stalled  = out_valid && !ordy;
    prev_data = out_data;
    @(negedge clk);
    if (fire_out) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (fire_in) begin
      exp_q.push_back(ref_avg(s));
      tag_q.push_back(tag);
    end
    chk({63'd0, out_valid}, {63'd0, exp_q.size() != 0}, "R9");
    if (exp_q.size() != 0) chk(out_data, exp_q[0], tag_q[0]);
    if (stalled) chk(out_data, prev_data, "R10");
    if (fire_out && !fire_in) chk({63'd0, out_valid}, 64'd0, "R11");
  endtask

  function automatic stim_t mk_stim(logic [63:0] a, logic [63:0] b, logic sub,
                                    logic [1:0] esz, logic [1:0] rm);
    stim_t s;
    s.a = a; s.b = b; s.sc = '0; s.old = 64'hDEAD_BEEF_0BAD_F00D; s.imm = '0;
    s.sub = sub; s.esz = esz; s.rm = rm; s.ops = 2'd0; s.men = 1'b0; s.mk = 8'hFF;
    return s;
  endfunction

  initial begin : watchdog
    #(2.0 * CLK_HALF * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    stim_t s;
    s = mk_stim('0, '0, 1'b0, 2'd0, 2'd0);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    src_a = '0; src_b = '0; scalar = '0; old_dst = '0; imm5 = '0;
    op_sub = 1'b0; elem_sz = '0; rnd_mode = '0; opnd_sel = '0; mask_en = 1'b0; mask = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({63'd0, out_valid}, 64'd0, "R1");
    chk({63'd0, in_ready}, 64'd1, "R1");

    // R4: rounding modes on 3 (+0) and 1 (+0) in all 8-bit lanes
    for (int m = 0; m < 4; m++) begin
      cycle(mk_stim({8{8'h03}}, '0, 1'b0, 2'd0, 2'(m)), 1'b1, 1'b1, "R4");
      cycle(mk_stim({8{8'h01}}, '0, 1'b0, 2'd0, 2'(m)), 1'b1, 1'b1, "R4");
      cycle(mk_stim({8{8'hFD}}, {8{8'h02}}, 1'b1, 2'd0, 2'(m)), 1'b1, 1'b1, "R4");
    end
    // R3: same words at each width
    for (int z = 0; z < 4; z++)
      cycle(mk_stim(64'h8123_7F45_00FF_9A01, 64'h7F01_8034_FFFF_1235, 1'b0, 2'(z), 2'd0),
            1'b1, 1'b1, "R3");
    // R5: 64-bit overflow corners in every mode; R2 same at 8 bits
    for (int m = 0; m < 4; m++) begin
      cycle(mk_stim(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 2'd3, 2'(m)), 1'b1, 1'b1, "R5");
      cycle(mk_stim(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'd3, 2'(m)), 1'b1, 1'b1, "R5");
      cycle(mk_stim(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 2'd3, 2'(m)), 1'b1, 1'b1, "R5");
      cycle(mk_stim(64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 2'd3, 2'(m)), 1'b1, 1'b1, "R5");
      cycle(mk_stim({8{8'h7F}}, {8{8'h80}}, 1'b1, 2'd0, 2'(m)), 1'b1, 1'b1, "R2");
      cycle(mk_stim({8{8'h80}}, {8{8'h80}}, 1'b0, 2'd0, 2'(m)), 1'b1, 1'b1, "R2");
    end
    // R6: scalar broadcast, and reserved select acting as vector
    for (int z = 0; z < 4; z++) begin
      s = mk_stim(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 1'b1, 2'(z), 2'd0);
      s.sc = 64'h8642_0000_1357_9BDF; s.ops = 2'd1;
      cycle(s, 1'b1, 1'b1, "R6");
      s.ops = 2'd3;
      cycle(s, 1'b1, 1'b1, "R6");
    end
    // R7: immediate with op_sub set still adds
    for (int z = 0; z < 4; z++) begin
      s = mk_stim(64'h1111_2222_F333_0044, 64'h5555_5555_5555_5555, 1'b1, 2'(z), 2'd1);
      s.ops = 2'd2; s.imm = 5'h10;
      cycle(s, 1'b1, 1'b1, "R7");
      s.imm = 5'h0F;
      cycle(s, 1'b1, 1'b1, "R7");
    end
    // R8: masking on and off
    for (int z = 0; z < 4; z++) begin
      s = mk_stim(64'h7766_5544_3322_1100, 64'h0102_0304_0506_0708, 1'b0, 2'(z), 2'd0);
      s.men = 1'b1; s.mk = 8'hA5;
      cycle(s, 1'b1, 1'b1, "R8");
      s.mk = 8'h00;
      cycle(s, 1'b1, 1'b1, "R8");
      s.men = 1'b0;
      cycle(s, 1'b1, 1'b1, "R8");
    end
    // Stall and drain sequence
    s = mk_stim(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1, 2'd1, 2'd3);
    cycle(s, 1'b1, 1'b0, "R9");
    cycle(s, 1'b1, 1'b0, "R10");
    cycle(s, 1'b0, 1'b0, "R10");
    cycle(s, 1'b0, 1'b1, "R11");
    cycle(s, 1'b0, 1'b1, "R11");

    // Random traffic with random handshakes
    for (int n = 0; n < 4000; n++) begin
      string tg;
      s.a   = {$urandom, $urandom};
      s.b   = {$urandom, $urandom};
      s.sc  = {$urandom, $urandom};
      s.old = {$urandom, $urandom};
      s.imm = 5'($urandom);
      s.sub = 1'($urandom);
      s.esz = 2'($urandom);
      s.rm  = 2'($urandom);
      s.ops = 2'($urandom);
      s.men = 1'($urandom);
      s.mk  = 8'($urandom);
      if ($urandom_range(0, 7) == 0) s.a = {$urandom_range(0, 1) ? 1'b1 : 1'b0, {63{s.a[0]}}};
      if ($urandom_range(0, 7) == 0) s.b = {$urandom_range(0, 1) ? 1'b1 : 1'b0, {63{s.b[0]}}};
      if (s.ops == 2'd2)      tg = "R7";
      else if (s.ops == 2'd1) tg = "R6";
      else if (s.men)         tg = "R8";
      else if (s.esz == 2'd3) tg = "R5";
      else                    tg = "R2";
      cycle(s, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), tg);
    end
    cycle(s, 1'b0, 1'b1, "R11");
    finish_run();
  end

endmodule